// File: doc/BRIEF.md
# Two-Step Transmit Timestamp Queue

This block holds egress timestamps for two-step precision time protocol frames until software collects them. Each time a frame marked for two-step handling leaves a port, the egress logic raises a single request carrying the port number, the nanosecond time of egress and the 9-bit frame identifier. The block turns this request into two queue entries written on consecutive clock edges. The first is a transmit stamp holding the port and the time. The second is an identifier entry whose stamp and sub-nanosecond fields together carry the frame identifier.

Software sees the oldest entry through a set of head outputs: a valid flag, a sticky overflow flag, a flag marking the head as a transmit stamp, the port, the stamp field and the sub-nanosecond field. A one-cycle pop strobe discards the head and exposes the next entry. The pair is admitted only as a whole: a request that cannot place both entries is dropped and raises the overflow flag. The flag stays set until a clear strobe is given.

Top module: `twostep_ts_fifo`

## Requirements
- R1: After a synchronous active-low reset the queue is empty (head valid low) and the overflow flag is low.
- R2: An accepted request writes a transmit entry on the same clock edge: is-transmit = 1, port = request port, stamp = request nanoseconds, sub-nanosecond field = 0.
- R3: On the next clock edge after an accepted request, the identifier entry is written directly behind the transmit entry. It has is-transmit = 0 and the same port. Its stamp field holds identifier bit 8 in bit 0, with zeros above. Its sub-nanosecond field holds identifier bits 7:0, so identifier = (stamp << 8) | subns.
- R4: Entries leave in the order they were written. A pop strobe sampled at an edge removes exactly one head entry.
- R5: A pop strobe sampled while the queue is empty has no effect.
- R6: A request is accepted only when, before that edge, at most DEPTH-2 entries are held (DEPTH = 16 by default). Otherwise neither entry is written and the overflow flag is set.
- R7: A request sampled on the edge right after an accepted request is dropped entirely, and the overflow flag is set.
- R8: The overflow flag stays set until a clear strobe is sampled. If a drop and a clear arrive on the same edge, the flag ends set.
- R9: When a write and a pop are sampled on the same edge of a non-empty queue, the occupancy is unchanged, and the queue contents match a reference queue under mixed random traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stamp_req | input | 1 | One-cycle request to record a two-step frame |
| stamp_port | input | 7 | Egress port of the frame |
| stamp_ns | input | 30 | Nanosecond time of egress |
| stamp_fid | input | 9 | Frame identifier, 0 to 511 |
| next_pop | input | 1 | Strobe that discards the head entry |
| ovfl_clr | input | 1 | Strobe that clears the overflow flag |
| head_valid | output | 1 | Head entry present |
| head_ovfl | output | 1 | Sticky overflow flag |
| head_is_tx | output | 1 | Head is a transmit stamp (1) or an identifier entry (0) |
| head_port | output | 7 | Port of the head entry |
| head_ns | output | 30 | Stamp field of the head entry |
| head_subns | output | 8 | Sub-nanosecond field of the head entry |

## Verification
The head outputs are driven combinationally from the storage. A write or pop sampled at an edge therefore shows on the head outputs within that same cycle after the edge. The identifier entry of a pair appears one edge after its transmit entry, and the overflow flag changes on the edge that samples the drop or the clear. The bench drives inputs just after a falling edge and advances a reference queue with the same edge semantics. It compares every head output at the next falling edge, a half period after the sampling edge, so each result is checked in the first cycle it is due.

// File: rtl/tsf_pkg.sv
// Shared widths and the entry layout for the two-step timestamp queue.
// Assumes one identifier entry per transmit entry, with a 9-bit identifier
// split as one stamp bit plus eight sub-nanosecond bits.
package tsf_pkg;
    localparam int TSF_PORT_W = 7;
    localparam int TSF_NS_W   = 30;
    localparam int TSF_SUB_W  = 8;
    localparam int TSF_FID_W  = 9;

    typedef struct packed {
        logic                  is_tx;
        logic [TSF_PORT_W-1:0] port;
        logic [TSF_NS_W-1:0]   nsec;
        logic [TSF_SUB_W-1:0]  subns;
    } tsf_entry_t;
endpackage

// File: rtl/tsf_pair_writer.sv
// Turns one accepted request into two writes on consecutive edges.
// The transmit entry is written on the accept edge. The identifier entry
// follows on the next edge. Assumes the caller never accepts while busy.
module tsf_pair_writer
    import tsf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic [TSF_PORT_W-1:0] req_port,
    input  logic [TSF_NS_W-1:0]   req_ns,
    input  logic [TSF_FID_W-1:0]  req_fid,
    output logic                  busy,
    output logic                  wr_en,
    output tsf_entry_t            wr_entry
);
    logic [TSF_PORT_W-1:0] held_port;
    logic [TSF_FID_W-1:0]  held_fid;

    // Remember the second half of the pair for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            held_port <= '0;
            held_fid  <= '0;
        end else begin
            busy <= accept;
            if (accept) begin
                held_port <= req_port;
                held_fid  <= req_fid;
            end
        end
    end

    // Pick which entry goes to storage this cycle.
    always_comb begin
        wr_en = accept | busy;
        if (busy) begin
            wr_entry.is_tx = 1'b0;
            wr_entry.port  = held_port;
            wr_entry.nsec  = TSF_NS_W'(held_fid[TSF_FID_W-1:TSF_SUB_W]);
            wr_entry.subns = held_fid[TSF_SUB_W-1:0];
        end else begin
            wr_entry.is_tx = 1'b1;
            wr_entry.port  = req_port;
            wr_entry.nsec  = req_ns;
            wr_entry.subns = '0;
        end
    end

    // R7: no accept is presented while the second half is still pending.
    assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
endmodule

// File: rtl/tsf_ring.sv
// Circular entry store with head read-out and occupancy count.
// Assumes the writer never writes into a full store. A pop on an empty
// store is ignored.
module tsf_ring
    import tsf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  tsf_entry_t     wr_entry,
    input  logic           rd_req,
    output tsf_entry_t     head,
    output logic           head_vld,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    tsf_entry_t     mem [DEPTH];
    logic [AW-1:0]  wptr;
    logic [AW-1:0]  rptr;
    logic           rd_ok;

    assign rd_ok    = rd_req && (count != '0);
    assign head_vld = (count != '0);
    assign head     = mem[rptr];

    // Store an incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_entry;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (rd_ok) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + (AW+1)'(wr_en) - (AW+1)'(rd_ok);
        end
    end

    // R6: occupancy never goes past the depth.
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    // R5: a pop on an empty store with no write leaves it empty.
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_req && !wr_en) |=> (count == '0));
    // R9: a write together with an effective pop keeps the occupancy.
    assert_same_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_req && count != '0) |=> $stable(count));
endmodule

// File: rtl/tsf_sticky.sv
// Sticky error flag: set wins over clear, and the flag holds otherwise.
module tsf_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R8: without a clear, a set flag stays set.
    assert_ovfl_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/twostep_ts_fifo.sv
// Two-step transmit timestamp queue. It admits a request only when both
// entries of the pair fit and no earlier pair is half written. It flags
// every dropped request and shows the oldest entry on the head outputs.
// Assumes one request per frame, with inputs valid in the request cycle.
module twostep_ts_fifo
    import tsf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stamp_req,
    input  logic [TSF_PORT_W-1:0] stamp_port,
    input  logic [TSF_NS_W-1:0]   stamp_ns,
    input  logic [TSF_FID_W-1:0]  stamp_fid,
    input  logic                  next_pop,
    input  logic                  ovfl_clr,
    output logic                  head_valid,
    output logic                  head_ovfl,
    output logic                  head_is_tx,
    output logic [TSF_PORT_W-1:0] head_port,
    output logic [TSF_NS_W-1:0]   head_ns,
    output logic [TSF_SUB_W-1:0]  head_subns
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic           busy;
    logic           accept;
    logic           drop;
    logic           wr_en;
    tsf_entry_t     wr_entry;
    tsf_entry_t     head;
    logic [CW-1:0]  count;

    // Admit a pair only if two slots are free and the writer is idle.
    assign accept = stamp_req && !busy && (count <= CW'(DEPTH-2));
    assign drop   = stamp_req && !accept;

    tsf_pair_writer u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_port (stamp_port),
        .req_ns   (stamp_ns),
        .req_fid  (stamp_fid),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_entry (wr_entry)
    );

    tsf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .rd_req   (next_pop),
        .head     (head),
        .head_vld (head_valid),
        .count    (count)
    );

    tsf_sticky u_ovfl (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (drop),
        .clr   (ovfl_clr),
        .flag  (head_ovfl)
    );

    assign head_is_tx = head.is_tx;
    assign head_port  = head.port;
    assign head_ns    = head.nsec;
    assign head_subns = head.subns;

    // R3: an accepted pair is followed by an identifier write next edge.
    assert_pair_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (wr_en && !wr_entry.is_tx));
    // R6: a dropped request raises the overflow flag.
    assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> head_ovfl);
    // R2: after an accepted request the queue is not empty.
    assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> head_valid);
endmodule

// File: tb/twostep_ts_fifo_test.sv
module twostep_ts_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int EW         = 46;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stamp_req = 1'b0;
    logic [6:0] stamp_port = '0;
    logic [29:0] stamp_ns = '0;
    logic [8:0] stamp_fid = '0;
    logic       next_pop = 1'b0;
    logic       ovfl_clr = 1'b0;
    logic       head_valid, head_ovfl, head_is_tx;
    logic [6:0] head_port;
    logic [29:0] head_ns;
    logic [7:0] head_subns;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [EW-1:0] mq[$];
    bit            m_busy = 1'b0;
    logic [EW-1:0] m_held;
    bit            m_ovfl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twostep_ts_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .stamp_req(stamp_req), .stamp_port(stamp_port),
        .stamp_ns(stamp_ns), .stamp_fid(stamp_fid), .next_pop(next_pop),
        .ovfl_clr(ovfl_clr), .head_valid(head_valid), .head_ovfl(head_ovfl),
        .head_is_tx(head_is_tx), .head_port(head_port), .head_ns(head_ns),
        .head_subns(head_subns)
    );

    function automatic logic [EW-1:0] mk(input logic tx, input logic [6:0] p,
                                         input logic [29:0] ns, input logic [7:0] sb);
        return {tx, p, ns, sb};
    endfunction

    function automatic logic [EW-1:0] id_entry(input logic [6:0] p, input logic [8:0] fid);
        return mk(1'b0, p, {29'd0, fid[8]}, fid[7:0]);
    endfunction

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference step: same edge semantics as the requirements.
    task automatic model_edge(input bit req, input bit pop, input bit clr,
                              input logic [6:0] p, input logic [29:0] ns,
                              input logic [8:0] fid);
        bit acc;
        acc = req && !m_busy && (mq.size() <= DEPTH-2);
        if (pop && mq.size() > 0) void'(mq.pop_front());
        if (m_busy) mq.push_back(m_held);
        if (acc) begin
            mq.push_back(mk(1'b1, p, ns, 8'd0));
            m_held = id_entry(p, fid);
        end
        m_busy = acc;
        if (req && !acc) m_ovfl = 1'b1;
        else if (clr) m_ovfl = 1'b0;
    endtask

    task automatic compare(input string tag);
        logic [EW-1:0] e;
        check(tag, "valid", head_valid, mq.size() > 0);
        check(tag, "ovfl", head_ovfl, m_ovfl);
        if (mq.size() > 0) begin
            e = mq[0];
            check(tag, "is_tx", head_is_tx, e[45]);
            check(tag, "port", head_port, e[44:38]);
            check(tag, "ns", head_ns, e[37:8]);
            check(tag, "subns", head_subns, e[7:0]);
        end
    endtask

    // Drive one cycle after a falling edge, check at the next falling edge.
    task automatic step(input string tag, input bit req, input bit pop, input bit clr,
                        input logic [6:0] p, input logic [29:0] ns, input logic [8:0] fid);
        stamp_req = req; next_pop = pop; ovfl_clr = clr;
        stamp_port = p; stamp_ns = ns; stamp_fid = fid;
        model_edge(req, pop, clr, p, ns, fid);
        @(negedge clk);
        stamp_req = 1'b0; next_pop = 1'b0; ovfl_clr = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 1'b0, '0, '0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // Single pair, then drain it.
        step("R2", 1'b1, 1'b0, 1'b0, 7'd5, 30'd123456, 9'h1A5);
        idle("R3");
        step("R4", 1'b0, 1'b1, 1'b0, '0, '0, '0);
        check("R3", "fid", {head_ns[0], head_subns}, 9'h1A5);
        step("R4", 1'b0, 1'b1, 1'b0, '0, '0, '0);
        step("R5", 1'b0, 1'b1, 1'b0, '0, '0, '0);
        check("R5", "valid_empty", head_valid, 0);

        // Back-to-back requests: the second is dropped.
        step("R7", 1'b1, 1'b0, 1'b0, 7'd9, 30'd777, 9'd0);
        step("R7", 1'b1, 1'b0, 1'b0, 7'd10, 30'd888, 9'd511);
        check("R7", "ovfl_set", head_ovfl, 1);
        idle("R8");
        step("R8", 1'b0, 1'b0, 1'b1, '0, '0, '0);
        check("R8", "cleared", head_ovfl, 0);
        step("R4", 1'b0, 1'b1, 1'b0, '0, '0, '0);
        step("R4", 1'b0, 1'b1, 1'b0, '0, '0, '0);

        // Fill to the depth with spaced pairs, then overflow.
        for (int k = 0; k < DEPTH/2; k++) begin
            step("R6", 1'b1, 1'b0, 1'b0, 7'(k + 20), 30'(1000 + k), 9'(500 + k));
            idle("R6");
        end
        step("R6", 1'b1, 1'b0, 1'b0, 7'd99, 30'd5, 9'd3);
        check("R6", "ovfl_full", head_ovfl, 1);
        step("R6", 1'b0, 1'b1, 1'b1, '0, '0, '0);
        step("R6", 1'b1, 1'b0, 1'b0, 7'd98, 30'd6, 9'd4);
        check("R6", "ovfl_odd_free", head_ovfl, 1);
        step("R8", 1'b1, 1'b0, 1'b1, 7'd97, 30'd7, 9'd5);
        check("R8", "set_wins", head_ovfl, 1);
        step("R8", 1'b0, 1'b0, 1'b1, '0, '0, '0);
        step("R9", 1'b1, 1'b1, 1'b0, 7'd3, 30'd44, 9'd300);
        idle("R9");
        for (int k = 0; k < DEPTH; k++) step("R4", 1'b0, 1'b1, 1'b0, '0, '0, '0);

        // Mixed random traffic against the reference queue.
        for (int k = 0; k < 4000; k++) begin
            step("R9", ($urandom % 100) < 40, ($urandom % 100) < 45, ($urandom % 100) < 5,
                 7'($urandom), 30'($urandom), 9'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule